// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the write-side command interpreter of a byte-wide parallel NOR flash model. The host issues bus write cycles, each carrying an address and a data byte. The decoder matches these against the multi-cycle unlock and command patterns. When a sequence completes, it starts an embedded operation on a small internal byte array. A down-counter takes the place of the embedded program and erase timers. The `busy` output is high for as long as that counter runs.

Two programming paths exist. The standard path needs two unlock cycles, a program command and then the address/data cycle. The second path is a persistent fast-program mode. After it is entered, each byte takes only a command cycle and an address/data cycle, until the host leaves the mode with a two-cycle exit. A six-cycle chip erase first forces every byte to zero. When its counter expires, it sets every byte to all ones. A program operation can only clear bits. A synchronous hardware reset aborts whatever is running and returns the decoder to array-read state.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `busy` is 0 and `bypass_active` is 0.
- R2: The standard program sequence is four writes: (555h, AAh), (2AAh, 55h), (555h, A0h), then (target address, data). The array byte at the target changes only when `busy`, which rises after the fourth write, falls again.
- R3: A program stores the old byte ANDed with the written data, so no bit goes from 0 to 1.
- R4: The writes (555h, AAh), (2AAh, 55h), (555h, 20h) enter fast-program mode, and `bypass_active` reads 1.
- R5: In fast-program mode, a write of data A0h at any address followed by (target address, data) programs that byte.
- R6: In fast-program mode every write other than A0h or the exit sequence is ignored, including a complete chip-erase sequence. No operation starts and the array is unchanged.
- R7: In fast-program mode, data 90h followed by data 00h, at any addresses, leaves the mode. A 90h followed by any other byte keeps the mode. Once out of the mode, a lone A0h no longer starts a program.
- R8: Chip erase is six writes: (555h, AAh), (2AAh, 55h), (555h, 80h), (555h, AAh), (2AAh, 55h), (555h, 10h). While it runs, every byte reads 00h. After it, every byte reads FFh.
- R9: Writes that arrive while `busy` is high are ignored. They neither alter the array nor advance a command sequence.
- R10: A write that breaks an expected sequence returns the decoder to array read (or to fast-program idle when that mode is active). The later cycles of the broken sequence then have no effect.
- R11: Reset during a program drops `busy` and `bypass_active` on the next clock, and the target byte keeps its old value.
- R12: `busy` stays high for exactly PGM_CYC clocks after a program and ERS_CYC clocks after a chip erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | CMD_AW | Write address |
| wr_data | input | 8 | Write data / command byte |
| rd_addr | input | ARR_AW | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` |
| busy | output | 1 | Embedded operation in progress |
| bypass_active | output | 1 | Fast-program mode is active |

## Verification
The hardest cases to reach are those where a command stream lands on the decoder while it cannot accept it. One is a complete program sequence issued during an embedded operation. Another is a full chip-erase sequence issued while fast-program mode is active. Others are a reset that lands partway through a program, or a broken unlock whose later cycles would still look valid on their own. The stimulus places these writes one per clock directly after the start of a program. It replays a full erase sequence inside fast-program mode, and it pulses reset a few cycles into a fast-mode program. After each of these, it reads back the bytes that could have changed.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // unlock addresses (compared after width adaptation)
    localparam int UNLK_ADDR_A = 'h555;
    localparam int UNLK_ADDR_B = 'h2AA;

    // command and unlock data bytes
    localparam byte_t KEY_FIRST    = 8'hAA;
    localparam byte_t KEY_SECOND   = 8'h55;
    localparam byte_t CMD_PROGRAM  = 8'hA0;
    localparam byte_t CMD_ERS_PREP = 8'h80;
    localparam byte_t CMD_ERS_CHIP = 8'h10;
    localparam byte_t CMD_FAST_ON  = 8'h20;
    localparam byte_t CMD_FAST_OFF = 8'h90;
    localparam byte_t CMD_FAST_END = 8'h00;

    localparam byte_t ERASED_BYTE  = 8'hFF;
    localparam byte_t CLEARED_BYTE = 8'h00;

    typedef enum logic [3:0] {
        SQ_READ,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PROG_DATA,
        SQ_ERS_PREP,
        SQ_ERS_KEY1,
        SQ_ERS_KEY2,
        SQ_FAST_IDLE,
        SQ_FAST_DATA,
        SQ_FAST_OFF,
        SQ_BUSY
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_ERASE
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        byte_t    data;
    } op_req_t;

    // program can only clear bits
    function automatic byte_t merge_program(input byte_t old_v, input byte_t new_v);
        return old_v & new_v;
    endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
    import flash_cmd_pkg::*;
#(
    parameter int CMD_AW = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CMD_AW-1:0] wr_addr,
    input  byte_t             wr_data,
    input  logic              op_done,
    output op_req_t           req,
    output logic              fast_mode
);

    localparam logic [CMD_AW-1:0] ADDR_A = CMD_AW'(UNLK_ADDR_A);
    localparam logic [CMD_AW-1:0] ADDR_B = CMD_AW'(UNLK_ADDR_B);

    seq_state_e state_q, state_d;
    logic       fast_q, fast_d;

    logic hit_key1, hit_key2;
    logic hit_prog, hit_prep, hit_chip, hit_fast_on;

    always_comb begin
        hit_key1    = (wr_addr == ADDR_A) && (wr_data == KEY_FIRST);
        hit_key2    = (wr_addr == ADDR_B) && (wr_data == KEY_SECOND);
        hit_prog    = (wr_addr == ADDR_A) && (wr_data == CMD_PROGRAM);
        hit_prep    = (wr_addr == ADDR_A) && (wr_data == CMD_ERS_PREP);
        hit_chip    = (wr_addr == ADDR_A) && (wr_data == CMD_ERS_CHIP);
        hit_fast_on = (wr_addr == ADDR_A) && (wr_data == CMD_FAST_ON);
    end

    always_comb begin
        state_d   = state_q;
        fast_d    = fast_q;
        req.kind  = OP_NONE;
        req.data  = wr_data;
        unique case (state_q)
            SQ_READ: begin
                if (wr_en && hit_key1) state_d = SQ_KEY1;
            end
            SQ_KEY1: begin
                if (wr_en) state_d = hit_key2 ? SQ_KEY2 : SQ_READ;
            end
            SQ_KEY2: begin
                if (wr_en) begin
                    if (hit_prog) begin
                        state_d = SQ_PROG_DATA;
                    end else if (hit_prep) begin
                        state_d = SQ_ERS_PREP;
                    end else if (hit_fast_on) begin
                        state_d = SQ_FAST_IDLE;
                        fast_d  = 1'b1;
                    end else begin
                        state_d = SQ_READ;
                    end
                end
            end
            SQ_PROG_DATA: begin
                if (wr_en) begin
                    req.kind = OP_PROG;
                    state_d  = SQ_BUSY;
                end
            end
            SQ_ERS_PREP: begin
                if (wr_en) state_d = hit_key1 ? SQ_ERS_KEY1 : SQ_READ;
            end
            SQ_ERS_KEY1: begin
                if (wr_en) state_d = hit_key2 ? SQ_ERS_KEY2 : SQ_READ;
            end
            SQ_ERS_KEY2: begin
                if (wr_en) begin
                    if (hit_chip) begin
                        req.kind = OP_ERASE;
                        state_d  = SQ_BUSY;
                    end else begin
                        state_d = SQ_READ;
                    end
                end
            end
            SQ_FAST_IDLE: begin
                if (wr_en) begin
                    if (wr_data == CMD_PROGRAM)       state_d = SQ_FAST_DATA;
                    else if (wr_data == CMD_FAST_OFF) state_d = SQ_FAST_OFF;
                end
            end
            SQ_FAST_DATA: begin
                if (wr_en) begin
                    req.kind = OP_PROG;
                    state_d  = SQ_BUSY;
                end
            end
            SQ_FAST_OFF: begin
                if (wr_en) begin
                    if (wr_data == CMD_FAST_END) begin
                        fast_d  = 1'b0;
                        state_d = SQ_READ;
                    end else begin
                        state_d = SQ_FAST_IDLE;
                    end
                end
            end
            SQ_BUSY: begin
                if (op_done) state_d = fast_q ? SQ_FAST_IDLE : SQ_READ;
            end
            default: begin
                state_d = SQ_READ;
                fast_d  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_READ;
            fast_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fast_q  <= fast_d;
        end
    end

    assign fast_mode = fast_q;

endmodule

// File: rtl/fcd_timer.sv
module fcd_timer
    import flash_cmd_pkg::*;
#(
    parameter int PGM_CYC = 8,
    parameter int ERS_CYC = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  op_kind_e start_kind,
    output logic     busy,
    output logic     done
);

    localparam int LONGEST = (ERS_CYC > PGM_CYC) ? ERS_CYC : PGM_CYC;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] PGM_LOAD = CNT_W'(PGM_CYC);
    localparam logic [CNT_W-1:0] ERS_LOAD = CNT_W'(ERS_CYC);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else begin
            unique case (start_kind)
                OP_PROG:  remain_q <= PGM_LOAD;
                OP_ERASE: remain_q <= ERS_LOAD;
                default: begin
                    if (remain_q != '0) remain_q <= remain_q - ONE;
                end
            endcase
        end
    end

    assign busy = (remain_q != '0);
    assign done = (remain_q == ONE);

endmodule

// File: rtl/fcd_array.sv
module fcd_array
    import flash_cmd_pkg::*;
#(
    parameter int ARR_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  op_req_t           req,
    input  logic [ARR_AW-1:0] req_addr,
    input  logic              op_done,
    input  logic [ARR_AW-1:0] rd_addr,
    output byte_t             rd_data
);

    localparam int DEPTH = 1 << ARR_AW;

    byte_t             cells [DEPTH];
    op_kind_e          pend_kind_q;
    logic [ARR_AW-1:0] pend_addr_q;
    byte_t             pend_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_kind_q <= OP_NONE;
            pend_addr_q <= '0;
            pend_data_q <= CLEARED_BYTE;
        end else begin
            if (req.kind != OP_NONE) begin
                pend_kind_q <= req.kind;
                pend_addr_q <= req_addr;
                pend_data_q <= req.data;
            end else if (op_done) begin
                pend_kind_q <= OP_NONE;
            end

            // erase phase one: preprogram everything to zero
            if (req.kind == OP_ERASE) begin
                for (int i = 0; i < DEPTH; i++) cells[i] <= CLEARED_BYTE;
            end

            if (op_done) begin
                if (pend_kind_q == OP_PROG) begin
                    cells[pend_addr_q] <= merge_program(cells[pend_addr_q], pend_data_q);
                end else if (pend_kind_q == OP_ERASE) begin
                    // erase phase two: whole array back to ones
                    for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED_BYTE;
                end
            end
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int CMD_AW  = 12,
    parameter int ARR_AW  = 4,
    parameter int PGM_CYC = 8,
    parameter int ERS_CYC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CMD_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ARR_AW-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              bypass_active
);

    op_req_t req;
    logic    op_done;

    fcd_seq #(.CMD_AW(CMD_AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .op_done   (op_done),
        .req       (req),
        .fast_mode (bypass_active)
    );

    fcd_timer #(.PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .start_kind (req.kind),
        .busy       (busy),
        .done       (op_done)
    );

    fcd_array #(.ARR_AW(ARR_AW)) u_array (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .req_addr (wr_addr[ARR_AW-1:0]),
        .op_done  (op_done),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int PGM_CYC = 8,
    parameter int ERS_CYC = 32
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       busy,
    input logic       bypass_active
);

    localparam int RUN_W = $clog2(ERS_CYC + PGM_CYC + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)       run_q <= '0;
        else if (busy) run_q <= run_q + RUN_W'(1);
        else           run_q <= '0;
    end

    // R12
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> (run_q == RUN_W'(PGM_CYC) || run_q == RUN_W'(ERS_CYC)));

    // R8
    busy_cap_chk: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_W'(ERS_CYC));

    // R4
    fast_enter_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bypass_active) |-> $past(wr_en && wr_data == 8'h20));

    // R7
    fast_exit_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(bypass_active) && !$past(rst)) |-> $past(wr_en && wr_data == 8'h00));

    // R9
    busy_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(bypass_active));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!busy && !bypass_active));

endmodule

bind flash_cmd_decoder fcd_checker #(.PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .busy          (busy),
    .bypass_active (bypass_active)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

    localparam int CMD_AW  = 12;
    localparam int ARR_AW  = 4;
    localparam int PGM_CYC = 8;
    localparam int ERS_CYC = 32;

    localparam logic [1:0] V_WR = 2'd0;  // write a = addr, d = data
    localparam logic [1:0] V_ID = 2'd1;  // idle d clocks
    localparam logic [1:0] V_RD = 2'd2;  // expect array[a] == d
    localparam logic [1:0] V_FL = 2'd3;  // expect {bypass_active,busy} == d[1:0]

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] a;
        logic [7:0]  d;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 49;
    localparam vec_t TBL [NVEC] = '{
        '{V_FL, 12'h000, 8'h00, 8'd1},   // R1 reset state
        '{V_WR, 12'h555, 8'hAA, 8'd8},   // R8 chip erase
        '{V_WR, 12'h2AA, 8'h55, 8'd8},
        '{V_WR, 12'h555, 8'h80, 8'd8},
        '{V_WR, 12'h555, 8'hAA, 8'd8},
        '{V_WR, 12'h2AA, 8'h55, 8'd8},
        '{V_WR, 12'h555, 8'h10, 8'd8},
        '{V_FL, 12'h000, 8'h01, 8'd8},
        '{V_RD, 12'h003, 8'h00, 8'd8},   // R8 zeros while running
        '{V_ID, 12'h000, 8'd31, 8'd12},
        '{V_FL, 12'h000, 8'h01, 8'd12},  // R12 still busy at ERS_CYC-1
        '{V_ID, 12'h000, 8'd1,  8'd12},
        '{V_FL, 12'h000, 8'h00, 8'd12},  // R12 low at ERS_CYC
        '{V_RD, 12'h003, 8'hFF, 8'd8},
        '{V_RD, 12'h00F, 8'hFF, 8'd8},
        '{V_WR, 12'h555, 8'hAA, 8'd2},   // R2 standard program
        '{V_WR, 12'h2AA, 8'h55, 8'd2},
        '{V_WR, 12'h555, 8'hA0, 8'd2},
        '{V_WR, 12'h003, 8'h5A, 8'd2},
        '{V_FL, 12'h000, 8'h01, 8'd2},
        '{V_RD, 12'h003, 8'hFF, 8'd2},   // R2 not yet written
        '{V_ID, 12'h000, 8'd8,  8'd2},
        '{V_FL, 12'h000, 8'h00, 8'd2},
        '{V_RD, 12'h003, 8'h5A, 8'd2},
        '{V_WR, 12'h555, 8'hAA, 8'd3},   // R3 AND merge
        '{V_WR, 12'h2AA, 8'h55, 8'd3},
        '{V_WR, 12'h555, 8'hA0, 8'd3},
        '{V_WR, 12'h003, 8'hF0, 8'd3},
        '{V_ID, 12'h000, 8'd8,  8'd3},
        '{V_RD, 12'h003, 8'h50, 8'd3},
        '{V_WR, 12'h555, 8'hAA, 8'd10},  // R10 broken unlock
        '{V_WR, 12'h123, 8'h55, 8'd10},
        '{V_WR, 12'h555, 8'hA0, 8'd10},
        '{V_WR, 12'h004, 8'h00, 8'd10},
        '{V_ID, 12'h000, 8'd8,  8'd10},
        '{V_FL, 12'h000, 8'h00, 8'd10},
        '{V_RD, 12'h004, 8'hFF, 8'd10},
        '{V_WR, 12'h555, 8'hAA, 8'd9},   // R9 writes during busy
        '{V_WR, 12'h2AA, 8'h55, 8'd9},
        '{V_WR, 12'h555, 8'hA0, 8'd9},
        '{V_WR, 12'h005, 8'h0F, 8'd9},
        '{V_WR, 12'h005, 8'h00, 8'd9},
        '{V_WR, 12'h555, 8'hAA, 8'd9},
        '{V_WR, 12'h2AA, 8'h55, 8'd9},
        '{V_WR, 12'h555, 8'hA0, 8'd9},
        '{V_ID, 12'h000, 8'd8,  8'd9},
        '{V_WR, 12'h006, 8'h00, 8'd9},
        '{V_ID, 12'h000, 8'd8,  8'd9},
        '{V_RD, 12'h005, 8'h0F, 8'd9}
    };

    logic              clk;
    logic              rst;
    logic              wr_en;
    logic [CMD_AW-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [ARR_AW-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic              busy;
    logic              bypass_active;

    int applied;
    int miscompares;
    bit finished;

    flash_cmd_decoder #(
        .CMD_AW(CMD_AW), .ARR_AW(ARR_AW), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)
    ) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .bypass_active(bypass_active)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic compare(input logic [7:0] got, input logic [7:0] exp, input int rq);
        applied++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL R%0d: actual %02h expected %02h at %0t", rq, got, exp, $time);
        end
    endtask

    task automatic run_vec(input vec_t v);
        case (v.op)
            V_WR: begin
                wr_en   = 1'b1;
                wr_addr = v.a;
                wr_data = v.d;
                @(posedge clk);
                @(negedge clk);
                wr_en   = 1'b0;
            end
            V_ID: begin
                for (int k = 0; k < int'(v.d); k++) @(negedge clk);
            end
            V_RD: begin
                rd_addr = v.a[ARR_AW-1:0];
                #1;
                compare(rd_data, v.d, int'(v.req));
            end
            default: begin
                compare({6'b0, bypass_active, busy}, v.d, int'(v.req));
            end
        endcase
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d, input int rq);
        run_vec('{V_WR, a, d, 8'(rq)});
    endtask

    task automatic idle(input int n);
        run_vec('{V_ID, 12'h000, 8'(n), 8'd0});
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [7:0] d, input int rq);
        run_vec('{V_RD, a, d, 8'(rq)});
    endtask

    task automatic fl_chk(input logic [7:0] d, input int rq);
        run_vec('{V_FL, 12'h000, d, 8'(rq)});
    endtask

    initial begin
        applied     = 0;
        miscompares = 0;
        finished    = 1'b0;
        rst     = 1'b1;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) run_vec(TBL[i]);
        rd_chk(12'h006, 8'hFF, 9);               // R9 later write ignored

        // R4 enter fast-program mode
        wr(12'h555, 8'hAA, 4);
        wr(12'h2AA, 8'h55, 4);
        wr(12'h555, 8'h20, 4);
        fl_chk(8'h02, 4);

        // R5 two-cycle program, command address ignored
        wr(12'h7F3, 8'hA0, 5);
        wr(12'h007, 8'h33, 5);
        fl_chk(8'h03, 5);
        idle(PGM_CYC);
        fl_chk(8'h02, 5);
        rd_chk(12'h007, 8'h33, 5);

        // R6 full erase sequence ignored in fast mode
        wr(12'h555, 8'hAA, 6);
        wr(12'h2AA, 8'h55, 6);
        wr(12'h555, 8'h80, 6);
        wr(12'h555, 8'hAA, 6);
        wr(12'h2AA, 8'h55, 6);
        wr(12'h555, 8'h10, 6);
        fl_chk(8'h02, 6);
        rd_chk(12'h007, 8'h33, 6);

        // R7 incomplete exit keeps mode, full exit leaves it
        wr(12'h000, 8'h90, 7);
        wr(12'h000, 8'h12, 7);
        fl_chk(8'h02, 7);
        wr(12'h3A5, 8'h90, 7);
        wr(12'h111, 8'h00, 7);
        fl_chk(8'h00, 7);
        wr(12'h000, 8'hA0, 7);
        wr(12'h009, 8'h00, 7);
        idle(PGM_CYC);
        rd_chk(12'h009, 8'hFF, 7);

        // R12 program busy window
        wr(12'h555, 8'hAA, 12);
        wr(12'h2AA, 8'h55, 12);
        wr(12'h555, 8'hA0, 12);
        wr(12'h00A, 8'h77, 12);
        idle(PGM_CYC - 1);
        fl_chk(8'h01, 12);
        idle(1);
        fl_chk(8'h00, 12);
        rd_chk(12'h00A, 8'h77, 12);

        // R11 reset aborts a fast-mode program
        wr(12'h555, 8'hAA, 11);
        wr(12'h2AA, 8'h55, 11);
        wr(12'h555, 8'h20, 11);
        wr(12'h000, 8'hA0, 11);
        wr(12'h00B, 8'h00, 11);
        idle(3);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        fl_chk(8'h00, 11);
        rd_chk(12'h00B, 8'hFF, 11);
        idle(PGM_CYC + 2);
        rd_chk(12'h00B, 8'hFF, 11);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            applied++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

endmodule